// File: doc/BRIEF.md
# Nine-Bit Multidrop Receive Address Filter

This block sits behind a nine-bit serial receiver on a shared master/slave bus. At each frame-complete strobe the block decides whether the frame reaches software. If it does, the block latches the byte and its ninth bit and sets a sticky receive-interrupt flag. If it does not, the frame leaves no trace. A ninth bit of 1 marks an address frame and a ninth bit of 0 marks a data frame.

Software programs three settings:
- a slave address;
- an address-enable mask;
- a filter-enable bit.

While the filter is enabled, only address frames that name this node raise the interrupt. A frame names the node when it passes either of two matches:
- the masked match, which compares only the bit positions selected by the mask;
- the broadcast match, which requires a 1 in every position where (address OR mask) is 1.

After software is addressed, it disables the filter so that the following data frames arrive. It re-enables the filter when the message ends.

The control state lives in two enumerated machines. The mode machine has two states. MODE_OPEN passes every frame. MODE_FILTER passes only matching address frames. A write to the filter-enable setting moves the mode machine to MODE_FILTER when wr_data[0] is 1 and to MODE_OPEN when it is 0. The flag machine also has two states, IRQ_IDLE and IRQ_PEND. An accepted frame moves it from IRQ_IDLE to IRQ_PEND. A clear pulse moves it from IRQ_PEND back to IRQ_IDLE, except in a cycle where a frame is also accepted.

Top module: `mpc_addr_filter`

## Requirements
- R1: After reset the outputs take these values: cfg_addr = 0x00, cfg_mask = 0x00, cfg_filt_en = 0 (MODE_OPEN), rx_irq = 0, rx_buf = 0x00 and rx_buf_b9 = 0.
- R2: A write strobe (wr_addr, wr_mask, or wr_filt with enable taken from wr_data[0]) updates its register at that clock edge. A frame that completes in the same cycle as the write is judged with the old settings.
- R3: With the filter disabled, every completed frame is accepted, data frames included.
- R4: With the filter enabled, a frame whose ninth bit is 0 is ignored.
- R5: With the filter enabled, an address frame is accepted when ((byte XOR address) AND mask) is zero. For example, address 0x35 with mask 0x0F accepts xxxx0101.
- R6: With the filter enabled, an address frame is accepted when (byte AND (address OR mask)) equals (address OR mask). For example, 0xF7 is the broadcast for address 0x35 with mask 0xF3, and 0xFF is accepted under any setting.
- R7: With the filter enabled, an address frame that passes neither match is ignored.
- R8: An accepted frame loads rx_buf and rx_buf_b9 and sets rx_irq at the same edge. An ignored frame changes none of the three.
- R9: rx_irq stays set until a one-cycle irq_clr pulse, which clears it at the next edge.
- R10: An irq_clr that arrives in the same cycle as an accepted frame leaves rx_irq set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_addr | input | 1 | Write strobe for the slave address register |
| wr_mask | input | 1 | Write strobe for the address-enable mask register |
| wr_filt | input | 1 | Write strobe for filter enable; wr_data[0] gives the new value |
| wr_data | input | 8 | Write data shared by the three strobes |
| rx_vld | input | 1 | Frame-complete strobe from the receiver (one cycle, at the stop bit) |
| rx_data | input | 8 | Received eight data bits |
| rx_b9 | input | 1 | Received ninth bit; 1 means address frame |
| irq_clr | input | 1 | Software clear pulse for the interrupt flag |
| cfg_addr | output | 8 | Current slave address |
| cfg_mask | output | 8 | Current address-enable mask |
| cfg_filt_en | output | 1 | Current filter enable (1 = MODE_FILTER) |
| rx_buf | output | 8 | Latched byte of the last accepted frame |
| rx_buf_b9 | output | 1 | Latched ninth bit of the last accepted frame |
| rx_irq | output | 1 | Sticky receive-interrupt flag |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the flag's software clear and the setting of the flag by a new accepted frame. The bench sets the flag and then pulses irq_clr alongside an accepted frame. It expects the flag still set and the buffer holding the new byte, and it repeats the pulse alone to confirm that the flag then drops.

The second pair is a configuration write and the judging of a frame. The bench turns the filter off in the same cycle as a non-matching address frame. It expects that frame to be ignored under the old setting and a frame sent afterwards to be accepted.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

    typedef enum logic {
        MODE_OPEN   = 1'b0,
        MODE_FILTER = 1'b1
    } mode_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_st_e;

endpackage

// File: rtl/uaf_cfg_regs.sv
module uaf_cfg_regs
    import uaf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_mask,
    input  logic          wr_filt,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] slv_addr,
    output logic [DW-1:0] slv_mask,
    output mode_e         mode
);

    localparam logic [DW-1:0] ZERO = '0;

    mode_e mode_q;
    mode_e mode_d;

    // Mode machine: next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_OPEN: begin
                if (wr_filt && wr_data[0]) mode_d = MODE_FILTER;
            end
            MODE_FILTER: begin
                if (wr_filt && !wr_data[0]) mode_d = MODE_OPEN;
            end
            default: mode_d = MODE_OPEN;
        endcase
    end

    // Mode machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_OPEN;
        else        mode_q <= mode_d;
    end

    // Address and mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_addr <= ZERO;
            slv_mask <= ZERO;
        end else begin
            if (wr_addr) slv_addr <= wr_data;
            if (wr_mask) slv_mask <= wr_data;
        end
    end

    assign mode = mode_q;

    AST_FILT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_filt |=> (mode == ($past(wr_data[0]) ? MODE_FILTER : MODE_OPEN))); // R2

    AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr |=> (slv_addr == $past(wr_data))); // R2

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_filt |=> $stable(mode)); // R2

endmodule

// File: rtl/uaf_addr_match.sv
module uaf_addr_match #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] slv_addr,
    input  logic [DW-1:0] slv_mask,
    output logic          hit_masked,
    output logic          hit_bcast
);

    logic [DW-1:0] msk_miss;
    logic [DW-1:0] bc_miss;

    // One compare cell per bit position
    for (genvar b = 0; b < DW; b++) begin : g_bit
        // Masked match: a checked position whose value differs
        assign msk_miss[b] = slv_mask[b] & (rx_byte[b] ^ slv_addr[b]);
        // Broadcast match: a required 1 that is missing
        assign bc_miss[b]  = (slv_addr[b] | slv_mask[b]) & ~rx_byte[b];
    end

    assign hit_masked = ~|msk_miss;
    assign hit_bcast  = ~|bc_miss;

    always_comb begin
        if (&rx_byte) begin
            AST_ALL_ONES_BCAST: assert (hit_bcast); // R6
        end
    end

endmodule

// File: rtl/uaf_rx_latch.sv
module uaf_rx_latch
    import uaf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_b9,
    input  mode_e         mode,
    input  logic          addr_hit,
    input  logic          irq_clr,
    output logic [DW-1:0] rx_buf,
    output logic          rx_buf_b9,
    output logic          rx_irq
);

    localparam logic [DW-1:0] ZERO = '0;

    irq_st_e irq_q;
    irq_st_e irq_d;
    logic    take;

    // Frame decision
    always_comb begin
        take = 1'b0;
        if (rx_vld) begin
            unique case (mode)
                MODE_OPEN:   take = 1'b1;
                MODE_FILTER: take = rx_b9 & addr_hit;
                default:     take = 1'b0;
            endcase
        end
    end

    // Flag machine: next-state logic
    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_IDLE: if (take)               irq_d = IRQ_PEND;
            IRQ_PEND: if (irq_clr && !take)   irq_d = IRQ_IDLE;
            default:                          irq_d = IRQ_IDLE;
        endcase
    end

    // Flag machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= IRQ_IDLE;
        else        irq_q <= irq_d;
    end

    // Receive buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf    <= ZERO;
            rx_buf_b9 <= 1'b0;
        end else if (take) begin
            rx_buf    <= rx_data;
            rx_buf_b9 <= rx_b9;
        end
    end

    // Output process
    always_comb rx_irq = (irq_q == IRQ_PEND);

    AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && mode == MODE_OPEN) |=> (rx_irq && rx_buf == $past(rx_data))); // R3

    AST_DATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && mode == MODE_FILTER && !rx_b9) |=> ($stable(rx_buf) && $stable(rx_buf_b9))); // R4

    AST_NOHIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && mode == MODE_FILTER && !addr_hit) |=> $stable(rx_buf)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !irq_clr) |=> rx_irq); // R9

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !rx_vld) |=> !rx_irq); // R9

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && rx_vld && mode == MODE_OPEN) |=> rx_irq); // R10

endmodule

// File: rtl/mpc_addr_filter.sv
module mpc_addr_filter
    import uaf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_mask,
    input  logic          wr_filt,
    input  logic [DW-1:0] wr_data,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_b9,
    input  logic          irq_clr,
    output logic [DW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_mask,
    output logic          cfg_filt_en,
    output logic [DW-1:0] rx_buf,
    output logic          rx_buf_b9,
    output logic          rx_irq
);

    mode_e mode;
    logic  hit_masked;
    logic  hit_bcast;

    uaf_cfg_regs #(.DW(DW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_addr  (wr_addr),
        .wr_mask  (wr_mask),
        .wr_filt  (wr_filt),
        .wr_data  (wr_data),
        .slv_addr (cfg_addr),
        .slv_mask (cfg_mask),
        .mode     (mode)
    );

    uaf_addr_match #(.DW(DW)) u_match (
        .rx_byte    (rx_data),
        .slv_addr   (cfg_addr),
        .slv_mask   (cfg_mask),
        .hit_masked (hit_masked),
        .hit_bcast  (hit_bcast)
    );

    uaf_rx_latch #(.DW(DW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_vld    (rx_vld),
        .rx_data   (rx_data),
        .rx_b9     (rx_b9),
        .mode      (mode),
        .addr_hit  (hit_masked | hit_bcast),
        .irq_clr   (irq_clr),
        .rx_buf    (rx_buf),
        .rx_buf_b9 (rx_buf_b9),
        .rx_irq    (rx_irq)
    );

    assign cfg_filt_en = (mode == MODE_FILTER);

endmodule

// File: tb/mpc_addr_filter_tb.sv
`timescale 1ns/1ps
module mpc_addr_filter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_addr = 1'b0, wr_mask = 1'b0, wr_filt = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_b9 = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] cfg_addr, cfg_mask, rx_buf;
    logic       cfg_filt_en, rx_buf_b9, rx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    mpc_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_filt(wr_filt), .wr_data(wr_data),
        .rx_vld(rx_vld), .rx_data(rx_data), .rx_b9(rx_b9), .irq_clr(irq_clr),
        .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_filt_en(cfg_filt_en),
        .rx_buf(rx_buf), .rx_buf_b9(rx_buf_b9), .rx_irq(rx_irq)
    );

    // addr, mask, filter, byte, ninth bit, expected accept
    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] mask;
        logic       filt;
        logic [7:0] data;
        logic       b9;
        logic       acc;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'h35, 8'h0F, 1'b1, 8'hA5, 1'b1, 1'b1}, // R5 xxxx0101
        '{8'h35, 8'h0F, 1'b1, 8'hA6, 1'b1, 1'b0}, // R7
        '{8'h35, 8'hF3, 1'b1, 8'h31, 1'b1, 1'b1}, // R5 0011xx01
        '{8'h35, 8'hF3, 1'b1, 8'h3D, 1'b1, 1'b1}, // R5
        '{8'h35, 8'hF3, 1'b1, 8'h75, 1'b1, 1'b0}, // R7
        '{8'h35, 8'hC0, 1'b1, 8'h2A, 1'b1, 1'b1}, // R5 00xxxxxx
        '{8'h35, 8'hC0, 1'b1, 8'h80, 1'b1, 1'b0}, // R7
        '{8'h35, 8'h0F, 1'b1, 8'hFF, 1'b1, 1'b1}, // R6
        '{8'h35, 8'hF3, 1'b1, 8'hFF, 1'b1, 1'b1}, // R6
        '{8'h35, 8'hC0, 1'b1, 8'hFF, 1'b1, 1'b1}, // R6
        '{8'h35, 8'hF3, 1'b1, 8'hF7, 1'b1, 1'b1}, // R6 broadcast only
        '{8'h35, 8'hC0, 1'b1, 8'hF5, 1'b1, 1'b1}, // R6 broadcast only
        '{8'h35, 8'h0F, 1'b1, 8'h3F, 1'b1, 1'b1}, // R6 broadcast only
        '{8'h35, 8'h0F, 1'b1, 8'hA5, 1'b0, 1'b0}, // R4 data frame
        '{8'h35, 8'h0F, 1'b0, 8'h12, 1'b0, 1'b1}, // R3 data passes
        '{8'h35, 8'h0F, 1'b0, 8'hA6, 1'b1, 1'b1}  // R3 address passes
    };

    logic [7:0] exp_buf = 8'h00;
    logic       exp_b9  = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] a, input logic [7:0] m, input logic f);
        wr_addr = 1'b1; wr_data = a; step(); wr_addr = 1'b0;
        wr_mask = 1'b1; wr_data = m; step(); wr_mask = 1'b0;
        wr_filt = 1'b1; wr_data = {7'd0, f}; step(); wr_filt = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic with_clr);
        rx_vld = 1'b1; rx_data = d; rx_b9 = b9; irq_clr = with_clr;
        step();
        rx_vld = 1'b0; irq_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) step();
        // R1: reset state
        check("R1 addr", cfg_addr, 8'h00);
        check("R1 mask", cfg_mask, 8'h00);
        check("R1 filt", cfg_filt_en, 1'b0);
        check("R1 irq",  rx_irq, 1'b0);
        check("R1 buf",  rx_buf, 8'h00);
        check("R1 b9",   rx_buf_b9, 1'b0);
        rst_n = 1'b1;
        step();

        // Vector table
        for (int i = 0; i < NV; i++) begin
            write_cfg(VECS[i].addr, VECS[i].mask, VECS[i].filt);
            check("R2 readback addr", cfg_addr, VECS[i].addr);
            check("R2 readback mask", cfg_mask, VECS[i].mask);
            check("R2 readback filt", cfg_filt_en, VECS[i].filt);
            pulse_clr();
            check("R9 cleared", rx_irq, 1'b0);
            send(VECS[i].data, VECS[i].b9, 1'b0);
            if (VECS[i].acc) begin
                exp_buf = VECS[i].data;
                exp_b9  = VECS[i].b9;
            end
            check($sformatf("R8 vec%0d irq", i), rx_irq, VECS[i].acc);
            check($sformatf("R8 vec%0d buf", i), rx_buf, exp_buf);
            check($sformatf("R8 vec%0d b9", i),  rx_buf_b9, exp_b9);
        end

        // R9: sticky across idle cycles and ignored frames
        write_cfg(8'h35, 8'h0F, 1'b1);
        pulse_clr();
        send(8'h05, 1'b1, 1'b0);
        exp_buf = 8'h05; exp_b9 = 1'b1;
        repeat (5) step();
        send(8'h00, 1'b1, 1'b0); // ignored
        check("R9 sticky", rx_irq, 1'b1);
        check("R8 ignored keeps buf", rx_buf, exp_buf);
        pulse_clr();
        check("R9 clear drops", rx_irq, 1'b0);

        // R10: clear and accepted frame in one cycle
        send(8'h15, 1'b1, 1'b0);
        check("R10 pre set", rx_irq, 1'b1);
        send(8'h25, 1'b1, 1'b1);
        check("R10 flag kept", rx_irq, 1'b1);
        check("R10 buf loaded", rx_buf, 8'h25);
        pulse_clr();
        check("R10 later clear", rx_irq, 1'b0);

        // R2: write filter-off together with non-matching address frame
        wr_filt = 1'b1; wr_data = 8'h00;
        rx_vld = 1'b1; rx_data = 8'h00; rx_b9 = 1'b1;
        step();
        wr_filt = 1'b0; rx_vld = 1'b0;
        check("R2 old setting used", rx_irq, 1'b0);
        check("R2 buf unchanged", rx_buf, 8'h25);
        check("R2 filt now off", cfg_filt_en, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        check("R2 new setting used", rx_irq, 1'b1);
        check("R3 buf data", rx_buf, 8'h00);
        check("R3 b9 data", rx_buf_b9, 1'b0);

        // R4: filter on, data frame with matching byte ignored
        write_cfg(8'h35, 8'hFF, 1'b1);
        pulse_clr();
        send(8'h35, 1'b0, 1'b0);
        check("R4 irq", rx_irq, 1'b0);
        check("R4 buf", rx_buf, 8'h00);
        send(8'h35, 1'b1, 1'b0);
        check("R5 exact match", rx_irq, 1'b1);
        check("R5 b9", rx_buf_b9, 1'b1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule